// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire link to a delta-sigma converter. The link has three lines: an active-low select, a serial clock that the host drives, and a data line that the converter drives. The converter keeps converting whether or not the host is reading. When select is low, it shows its conversion state on the data line, so the reader drops select after a start request and watches that line. A low level means a result is waiting. The reader then generates the serial clock from the system clock and samples the data line on each rising edge. It collects a 32-bit word, most significant bit first, and releases select.

The word carries a three-bit prefix: a conversion-ready flag, a bit that must always read low, and the sign. After the prefix come a 24-bit result field and five extra low-order bits. The reader splits the word into these fields, raises an overrange or underrange flag from the sign and top result bit, and reports a frame error when the always-low bit reads high. Two conditions keep the reader off the link. After reset it waits a fixed power-up window before it accepts any request. If the ready flag stays high for too long, it gives up, releases select and reports a timeout.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, csN is high, sclk is low and busy is high for POWERUP_CYCLES clock cycles, and a startReq during that window has no effect (csN stays high).
- R2: startReq is accepted only while busy is low, and csN goes low in the cycle after acceptance. A startReq while a frame is in progress has no effect: no second frame follows it.
- R3: While csN is low and sdoIn is high, no sclk edge is produced. The first low seen on sdoIn starts the clocking.
- R4: If sdoIn stays high for TIMEOUT_CYCLES cycles after select drops, csN returns high with no sclk edge and timeoutErr goes high. timeoutErr stays high until the next accepted start, which clears it.
- R5: A frame uses exactly 32 rising sclk edges. Each phase of sclk lasts CLK_DIV cycles. sdoIn is sampled at each rising edge, and the first sample is word bit 31.
- R6: resultValid is a one-cycle pulse after the 32nd sample, with csN already high. All decoded outputs stay unchanged until the next pulse.
- R7: resultData equals word bits 28..5, subLsb equals word bits 4..0, and signPos equals word bit 29.
- R8: overRange is high when word bits 29 and 28 are both 1. underRange is high when both are 0. Neither flag is high for any other combination.
- R9: frameErr is high exactly when word bit 30 (the always-low bit) reads 1.
- R10: sclk is low whenever csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to read one frame |
| sdoIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High during power-up wait or while a read is in progress |
| resultValid | output | 1 | One-cycle pulse when the decoded fields are updated |
| resultData | output | 24 | Result field (word bits 28..5) |
| subLsb | output | 5 | Extra low-order bits (word bits 4..0) |
| signPos | output | 1 | Sign bit, high for a positive input |
| overRange | output | 1 | Input above positive full scale |
| underRange | output | 1 | Input below negative full scale |
| frameErr | output | 1 | Always-low bit read as 1 |
| timeoutErr | output | 1 | Ready flag did not appear in time |

## Verification
Two events can fall in the same cycle: the completion pulse of one frame and a start request for the next. The pulse is only issued once the reader is back in idle, so a start request in that cycle must be accepted. The bench raises startReq in exactly the cycle where it sees resultValid high. It then expects select to drop one cycle later, the pulse to be gone, and the previous result to remain on the outputs. The second frame must then decode to its own values.

// File: rtl/adc_reader_pkg.sv
`timescale 1ns/1ps
package adc_reader_pkg;
  localparam int RES_W      = 24;
  localparam int SUB_W      = 5;
  localparam int FRAME_BITS = 3 + RES_W + SUB_W;
  localparam int POS_DUMMY  = FRAME_BITS - 2;
  localparam int POS_SIGN   = FRAME_BITS - 3;
  localparam int POS_MSB    = FRAME_BITS - 4;

  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_POLL, ST_SHIFT, ST_DONE
  } readerState_t;

  typedef struct packed {
    logic shift;
    logic latch;
  } dpCtl_t;
endpackage

// File: rtl/adc_reader_ctrl.sv
`timescale 1ns/1ps
module adc_reader_ctrl
  import adc_reader_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int POWERUP_CYCLES = 200000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   sdoIn,
  output logic   csN,
  output logic   sclk,
  output logic   busy,
  output logic   timeoutErr,
  output dpCtl_t dpCtl
);
  localparam int DIV_W = $clog2(CLK_DIV) + 1;
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES) + 1;
  localparam int PWR_W = $clog2(POWERUP_CYCLES) + 1;
  localparam int BIT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PWR_W-1:0] PWR_LAST = PWR_W'(POWERUP_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  readerState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [TO_W-1:0]  waitCnt;
  logic [PWR_W-1:0] pwrCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             divEnd;

  assign divEnd = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_PWRUP;
      divCnt     <= '0;
      waitCnt    <= '0;
      pwrCnt     <= '0;
      bitCnt     <= '0;
      sclk       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      case (state)
        ST_PWRUP: begin
          if (pwrCnt == PWR_LAST) state <= ST_IDLE;
          else pwrCnt <= pwrCnt + 1'b1;
        end
        ST_IDLE: begin
          if (startReq) begin
            state      <= ST_POLL;
            waitCnt    <= '0;
            timeoutErr <= 1'b0;
          end
        end
        ST_POLL: begin
          if (!sdoIn) begin
            state  <= ST_SHIFT;
            divCnt <= '0;
            bitCnt <= '0;
          end else if (waitCnt == TO_LAST) begin
            state      <= ST_IDLE;
            timeoutErr <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (divEnd) begin
            divCnt <= '0;
            sclk   <= !sclk;
            if (!sclk) begin
              if (bitCnt == BIT_LAST) state <= ST_DONE;
              else bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: begin
          sclk  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.shift = (state == ST_SHIFT) && divEnd && !sclk;
    dpCtl.latch = (state == ST_DONE);
    csN         = !(state == ST_POLL || state == ST_SHIFT || state == ST_DONE);
    busy        = (state != ST_IDLE);
  end
endmodule

// File: rtl/adc_reader_dp.sv
`timescale 1ns/1ps
module adc_reader_dp
  import adc_reader_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdoIn,
  input  dpCtl_t           dpCtl,
  output logic             resultValid,
  output logic [RES_W-1:0] resultData,
  output logic [SUB_W-1:0] subLsb,
  output logic             signPos,
  output logic             overRange,
  output logic             underRange,
  output logic             frameErr
);
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      resultValid <= 1'b0;
      resultData  <= '0;
      subLsb      <= '0;
      signPos     <= 1'b0;
      overRange   <= 1'b0;
      underRange  <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      if (dpCtl.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], sdoIn};
      resultValid <= dpCtl.latch;
      if (dpCtl.latch) begin
        resultData <= shiftReg[POS_MSB -: RES_W];
        subLsb     <= shiftReg[SUB_W-1:0];
        signPos    <= shiftReg[POS_SIGN];
        overRange  <= shiftReg[POS_SIGN] && shiftReg[POS_MSB];
        underRange <= !shiftReg[POS_SIGN] && !shiftReg[POS_MSB];
        frameErr   <= shiftReg[POS_DUMMY];
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
`timescale 1ns/1ps
module adc_frame_reader
  import adc_reader_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int POWERUP_CYCLES = 200000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             sdoIn,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic             resultValid,
  output logic [RES_W-1:0] resultData,
  output logic [SUB_W-1:0] subLsb,
  output logic             signPos,
  output logic             overRange,
  output logic             underRange,
  output logic             frameErr,
  output logic             timeoutErr
);
  dpCtl_t dpCtl;

  adc_reader_ctrl #(
    .CLK_DIV(CLK_DIV), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .POWERUP_CYCLES(POWERUP_CYCLES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdoIn(sdoIn),
    .csN(csN), .sclk(sclk), .busy(busy), .timeoutErr(timeoutErr), .dpCtl(dpCtl)
  );

  adc_reader_dp dp (
    .clk(clk), .rstN(rstN), .sdoIn(sdoIn), .dpCtl(dpCtl),
    .resultValid(resultValid), .resultData(resultData), .subLsb(subLsb),
    .signPos(signPos), .overRange(overRange), .underRange(underRange), .frameErr(frameErr)
  );
endmodule

// File: rtl/adc_frame_reader_chk.sv
`timescale 1ns/1ps
module adc_frame_reader_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic csN,
  input logic sclk,
  input logic busy,
  input logic resultValid,
  input logic overRange,
  input logic underRange,
  input logic timeoutErr
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);  // R6
  AST_VALID_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> csN);  // R6
  AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(overRange && underRange));  // R8
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> ($past(startReq) && !$past(busy)));  // R2
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $rose(csN));  // R4
endmodule

bind adc_frame_reader adc_frame_reader_chk chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .csN(csN), .sclk(sclk),
  .busy(busy), .resultValid(resultValid), .overRange(overRange),
  .underRange(underRange), .timeoutErr(timeoutErr)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, startReq;
  logic sdoIn;
  logic csN, sclk, busy, resultValid, signPos, overRange, underRange, frameErr, timeoutErr;
  logic [23:0] resultData;
  logic [4:0]  subLsb;

  int nTests = 0;
  int nFail  = 0;

  adc_frame_reader #(.CLK_DIV(2), .TIMEOUT_CYCLES(200), .POWERUP_CYCLES(100)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdoIn(sdoIn), .csN(csN), .sclk(sclk),
    .busy(busy), .resultValid(resultValid), .resultData(resultData), .subLsb(subLsb),
    .signPos(signPos), .overRange(overRange), .underRange(underRange),
    .frameErr(frameErr), .timeoutErr(timeoutErr)
  );

  // converter model
  logic [31:0] frameWord = 32'h0;
  int eocWait = 10;
  int eocCnt  = 0;
  int idx     = 31;
  logic sclkQ = 1'b0;
  always @(posedge clk) begin
    sclkQ <= sclk;
    if (csN) begin
      eocCnt <= 0;
      idx    <= 31;
    end else begin
      if (eocCnt < 1000000) eocCnt <= eocCnt + 1;
      if (sclkQ && !sclk) idx <= idx - 1;
    end
  end
  assign sdoIn = csN ? 1'b1 : ((eocCnt < eocWait) ? 1'b1 : frameWord[idx[4:0]]);

  int riseCnt = 0;
  int sclkBad = 0;
  always @(posedge sclk) begin
    riseCnt = riseCnt + 1;
    if (csN) sclkBad = sclkBad + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitValid(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      if (resultValid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic checkFields(input logic [31:0] w);
    check("R7 resultData", 32'(resultData), 32'(w[28:5]));
    check("R7 subLsb", 32'(subLsb), 32'(w[4:0]));
    check("R7 signPos", 32'(signPos), 32'(w[29]));
    check("R8 overRange", 32'(overRange), 32'(w[29] & w[28]));
    check("R8 underRange", 32'(underRange), 32'(!w[29] & !w[28]));
    check("R9 frameErr", 32'(frameErr), 32'(w[30]));
  endtask

  task automatic testReset();
    int n;
    rstN = 1'b0; startReq = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 csN in reset", 32'(csN), 1);
    check("R1 sclk in reset", 32'(sclk), 0);
    check("R1 busy in reset", 32'(busy), 1);
    check("R6 valid in reset", 32'(resultValid), 0);
    rstN = 1'b1;
    n = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      startReq = (i == 20);
      if (!busy) begin n = i; break; end
    end
    startReq = 1'b0;
    check("R1 power-up length", 32'(n), 100);
    check("R1 start ignored during power-up", 32'(csN), 1);
  endtask

  task automatic testFrame(input logic [31:0] w);
    int base;
    bit seen;
    frameWord = w; eocWait = 12;
    base = riseCnt;
    pulseStart();
    check("R2 csN low after start", 32'(csN), 0);
    repeat (8) @(negedge clk);
    check("R3 no sclk while polling", 32'(riseCnt - base), 0);
    waitValid(seen);
    check("R6 valid seen", 32'(seen), 1);
    check("R6 csN released at valid", 32'(csN), 1);
    check("R5 rising edges per frame", 32'(riseCnt - base), 32);
    checkFields(w);
    @(negedge clk);
    check("R6 valid one cycle", 32'(resultValid), 0);
    check("R6 data held", 32'(resultData), 32'(w[28:5]));
  endtask

  task automatic testBusyStart();
    int base;
    bit seen;
    frameWord = 32'h2ABCDE15; eocWait = 4;
    pulseStart();
    repeat (40) @(negedge clk);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    waitValid(seen);
    base = riseCnt;
    repeat (20) @(negedge clk);
    check("R2 start while busy ignored (csN)", 32'(csN), 1);
    check("R2 start while busy ignored (sclk)", 32'(riseCnt - base), 0);
  endtask

  task automatic testBackToBack();
    bit seen;
    logic [31:0] w1, w2;
    w1 = 32'h2F00000A; w2 = 32'h10FEDC93;
    frameWord = w1; eocWait = 6;
    pulseStart();
    waitValid(seen);
    checkFields(w1);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    frameWord = w2;
    check("R2 start in valid cycle accepted", 32'(csN), 0);
    check("R6 pulse ended", 32'(resultValid), 0);
    check("R6 old data held", 32'(resultData), 32'(w1[28:5]));
    @(negedge clk);
    waitValid(seen);
    check("R6 second valid seen", 32'(seen), 1);
    checkFields(w2);
  endtask

  task automatic testTimeout();
    int base, n;
    eocWait = 1000000;
    base = riseCnt;
    pulseStart();
    n = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (csN) begin n = i; break; end
    end
    check("R4 timeout length", 32'(n), 200);
    check("R4 timeoutErr set", 32'(timeoutErr), 1);
    check("R4 no sclk on timeout", 32'(riseCnt - base), 0);
    repeat (5) @(negedge clk);
    check("R4 timeoutErr held", 32'(timeoutErr), 1);
    eocWait = 3; frameWord = 32'h20000001;
    pulseStart();
    check("R4 timeoutErr cleared by start", 32'(timeoutErr), 0);
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testFrame(32'h2ABCDEF3);  // positive, in range
    testFrame(32'h1234567C);  // negative, in range
    testFrame(32'h3FFFFFFF & 32'h3C000011);  // over range
    testFrame(32'h00000000);  // under range
    testFrame(32'h60F0F0F5);  // dummy bit set: frame error
    testBusyStart();
    testBackToBack();
    testTimeout();
    check("R10 sclk low while deselected", 32'(sclkBad), 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule